// File: doc/BRIEF.md
# Multiply, Product Scaling and Accumulate Datapath

This block is the arithmetic core of a 16-bit fixed-point signal processor. It multiplies a 16-bit two's-complement multiplicand, held in its own register, by an incoming 16-bit operand and places the 32-bit result in a product register. A scaler then conditions that product in one of four fixed ways. The scaled product, or the incoming operand after a left shift of 0 to 16 places, feeds a 32-bit adder/subtractor. That adder updates the accumulator together with a carry flag and a sticky overflow flag, and can saturate the result.

The instruction decoder above this block presents one operation per cycle with a valid strobe, a shift count, a product-scale mode, a sign-extension mode and a saturation mode. Registered state changes on the clock edge that follows the strobe. A 32-bit buffer register can take a copy of the accumulator.

Top module: `mac_datapath`

## Requirements
- R1: After an active-low reset, the accumulator, buffer, product register and multiplicand register are zero, and the carry and overflow flags are clear.
- R2: Operation LDT (code 11) loads the operand into the multiplicand register. Operation MPY (code 12) writes the signed 32-bit product of the multiplicand register and the operand into the product register. Both take effect one clock after the strobe.
- R3: The scaled product used by LOADP (8), ADDP (9) and SUBP (10) is the product register unchanged for mode 00, shifted left by 1 with zero fill for mode 01, and shifted left by 4 with zero fill for mode 10.
- R4: Product-scale mode 11 is an arithmetic right shift by 6 that discards the 6 low bits and always sign-extends, whatever the sign-extension mode input says.
- R5: The scaled operand is the 16-bit operand shifted left by the shift count with zero fill in the low bits. Counts above 16 behave as 16. LOAD (1) writes the scaled operand into the accumulator.
- R6: When sxm is 1, the operand is sign-extended to 32 bits before it is shifted, for LOAD, ADD (2) and SUB (3). ADDC (4), ADDU (5), SUBB (6) and SUBU (7) always zero-extend it.
- R7: An add sets carry to the carry out of bit 31. A subtract sets carry to 1 when no borrow occurs and to 0 when one does. ADDC also adds the current carry. SUBB also subtracts the inverse of the current carry. Operations that do not add or subtract leave carry unchanged.
- R8: The overflow flag is set by an add or subtract whose signed 32-bit result overflows. It stays set until ov_clr is asserted. When an overflow and ov_clr fall in the same cycle, the flag ends set.
- R9: With ovm at 1, an overflowing add or subtract writes 0x7FFFFFFF to the accumulator when the true result is above the range, and 0x80000000 when it is below. With ovm at 0 the result wraps.
- R10: SAVEB (13) copies the accumulator into the buffer. NOP (0), and any cycle with op_valid low, leave the accumulator, buffer, product register, multiplicand register and carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe: execute op_sel this cycle |
| op_sel | input | 4 | Operation code (values in R2 to R10) |
| operand | input | 16 | Incoming data operand |
| shift_cnt | input | 5 | Left shift count for the operand |
| pscale_mode | input | 2 | Product scaler mode |
| sxm | input | 1 | Sign-extension mode for the operand |
| ovm | input | 1 | Saturation mode for add and subtract |
| ov_clr | input | 1 | Clears the sticky overflow flag |
| acc | output | 32 | Accumulator |
| accb | output | 32 | Accumulator buffer |
| preg | output | 32 | Product register |
| carry | output | 1 | Carry / not-borrow flag |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The two functions that can meet in one cycle are the overflow detection of an add or subtract and the explicit clear of the sticky overflow flag. The bench drives ov_clr in the same cycle as an add that is known to overflow, and separately asserts it alone. In the random phase it raises ov_clr at random against random arithmetic. A behavioural reference model predicts the flag in every case, set winning over clear, and each cycle the model's flag and the rest of the state are compared with the design's.

// File: rtl/mac_dp_pkg.sv
package mac_dp_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_ADDC  = 4'd4,
        OP_ADDU  = 4'd5,
        OP_SUBB  = 4'd6,
        OP_SUBU  = 4'd7,
        OP_LOADP = 4'd8,
        OP_ADDP  = 4'd9,
        OP_SUBP  = 4'd10,
        OP_LDT   = 4'd11,
        OP_MPY   = 4'd12,
        OP_SAVEB = 4'd13
    } op_e;

    typedef enum logic [1:0] {
        PS_NONE = 2'd0,
        PS_LSH1 = 2'd1,
        PS_LSH4 = 2'd2,
        PS_ASR6 = 2'd3
    } pscale_e;

    typedef struct packed {
        logic [31:0] res;
        logic        cout;
        logic        ovf;
        logic        wr_acc;
        logic        flags_upd;
    } alu_out_t;

endpackage

// File: rtl/mac_in_shifter.sv
module mac_in_shifter #(
    parameter int DW    = 16,
    parameter int SHW   = 5,
    parameter int MAXSH = 16
) (
    input  logic [DW-1:0]   opnd,
    input  logic [SHW-1:0]  cnt,
    input  logic            sext_en,
    output logic [2*DW-1:0] scaled
);
    localparam int AW = 2 * DW;
    localparam int CW = $clog2(MAXSH + 1);

    logic [CW-1:0] eff;
    logic [AW-1:0] stg [0:CW];

    // counts beyond the limit act as the limit
    assign eff    = (int'(cnt) > MAXSH) ? CW'(MAXSH) : CW'(cnt);
    assign stg[0] = {{DW{sext_en & opnd[DW-1]}}, opnd};

    for (genvar k = 0; k < CW; k++) begin : g_stage
        assign stg[k+1] = eff[k] ? (stg[k] << (1 << k)) : stg[k];
    end

    assign scaled = stg[CW];
endmodule

// File: rtl/mac_product_unit.sv
module mac_product_unit
    import mac_dp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_t,
    input  logic            do_mpy,
    input  logic [DW-1:0]   opnd,
    input  logic [1:0]      mode,
    output logic [2*DW-1:0] preg,
    output logic [2*DW-1:0] pscaled
);
    localparam int AW  = 2 * DW;
    localparam int SL1 = 1;
    localparam int SL4 = 4;
    localparam int SR6 = 6;

    logic [DW-1:0] treg;
    logic [AW-1:0] a_ext, b_ext, prod;

    assign a_ext = {{DW{treg[DW-1]}}, treg};
    assign b_ext = {{DW{opnd[DW-1]}}, opnd};
    assign prod  = a_ext * b_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            treg <= '0;
            preg <= '0;
        end else begin
            if (ld_t)   treg <= opnd;
            if (do_mpy) preg <= prod;
        end
    end

    always_comb begin
        unique case (pscale_e'(mode))
            PS_NONE: pscaled = preg;
            PS_LSH1: pscaled = preg << SL1;
            PS_LSH4: pscaled = preg << SL4;
            PS_ASR6: pscaled = AW'($signed(preg) >>> SR6);
            default: pscaled = preg;
        endcase
    end

    // R4: mode 11 output carries the product sign in its top bits
    a_r4_asr_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> ((pscaled[AW-1:AW-1-SR6] == '0) ||
                             (pscaled[AW-1:AW-1-SR6] == '1)));

    // R2: multiplying by zero empties the product register
    a_r2_mpy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (do_mpy && opnd == '0) |=> (preg == '0));
endmodule

// File: rtl/mac_alu.sv
module mac_alu
    import mac_dp_pkg::*;
#(
    parameter int AW = 32
) (
    input  op_e           op,
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] opd,
    input  logic [AW-1:0] prd,
    input  logic          carry_in,
    output alu_out_t      o
);
    logic [AW-1:0] b, bx;
    logic [AW:0]   sum;
    logic          sub, cin, arith;

    always_comb begin
        o     = '0;
        b     = opd;
        sub   = 1'b0;
        cin   = 1'b0;
        arith = 1'b0;
        unique case (op)
            OP_LOAD:          begin o.wr_acc = 1'b1; o.res = opd; end
            OP_LOADP:         begin o.wr_acc = 1'b1; o.res = prd; end
            OP_ADD, OP_ADDU:  arith = 1'b1;
            OP_ADDC:          begin arith = 1'b1; cin = carry_in; end
            OP_ADDP:          begin arith = 1'b1; b = prd; end
            OP_SUB, OP_SUBU:  begin arith = 1'b1; sub = 1'b1; cin = 1'b1; end
            OP_SUBB:          begin arith = 1'b1; sub = 1'b1; cin = carry_in; end
            OP_SUBP:          begin arith = 1'b1; sub = 1'b1; cin = 1'b1; b = prd; end
            default:          ;
        endcase
        bx  = sub ? ~b : b;
        sum = {1'b0, acc} + {1'b0, bx} + {{AW{1'b0}}, cin};
        if (arith) begin
            o.wr_acc    = 1'b1;
            o.flags_upd = 1'b1;
            o.res       = sum[AW-1:0];
            o.cout      = sum[AW];
            o.ovf       = (acc[AW-1] == bx[AW-1]) && (sum[AW-1] != acc[AW-1]);
        end
    end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_dp_pkg::*;
#(
    parameter int DW    = 16,
    parameter int SHW   = 5,
    parameter int MAXSH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_sel,
    input  logic [DW-1:0]   operand,
    input  logic [SHW-1:0]  shift_cnt,
    input  logic [1:0]      pscale_mode,
    input  logic            sxm,
    input  logic            ovm,
    input  logic            ov_clr,
    output logic [2*DW-1:0] acc,
    output logic [2*DW-1:0] accb,
    output logic [2*DW-1:0] preg,
    output logic            carry,
    output logic            ovf
);
    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] SAT_POS = {1'b0, {(AW-1){1'b1}}};
    localparam logic [AW-1:0] SAT_NEG = {1'b1, {(AW-1){1'b0}}};

    op_e           op;
    logic          no_sext, sext_en;
    logic [AW-1:0] opd_scaled, prd_scaled, acc_next;
    alu_out_t      alu_o;

    assign op      = op_e'(op_sel);
    assign no_sext = (op == OP_ADDC) || (op == OP_ADDU) ||
                     (op == OP_SUBB) || (op == OP_SUBU);
    assign sext_en = sxm && !no_sext;

    mac_in_shifter #(.DW(DW), .SHW(SHW), .MAXSH(MAXSH)) u_shift (
        .opnd    (operand),
        .cnt     (shift_cnt),
        .sext_en (sext_en),
        .scaled  (opd_scaled)
    );

    mac_product_unit #(.DW(DW)) u_prod (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_t    (op_valid && op == OP_LDT),
        .do_mpy  (op_valid && op == OP_MPY),
        .opnd    (operand),
        .mode    (pscale_mode),
        .preg    (preg),
        .pscaled (prd_scaled)
    );

    mac_alu #(.AW(AW)) u_alu (
        .op       (op),
        .acc      (acc),
        .opd      (opd_scaled),
        .prd      (prd_scaled),
        .carry_in (carry),
        .o        (alu_o)
    );

    // saturation direction follows the accumulator sign on overflow
    always_comb begin
        if (alu_o.flags_upd && alu_o.ovf && ovm)
            acc_next = acc[AW-1] ? SAT_NEG : SAT_POS;
        else
            acc_next = alu_o.res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc   <= '0;
            accb  <= '0;
            carry <= 1'b0;
            ovf   <= 1'b0;
        end else begin
            if (op_valid && alu_o.wr_acc)    acc   <= acc_next;
            if (op_valid && alu_o.flags_upd) carry <= alu_o.cout;
            if (op_valid && op == OP_SAVEB)  accb  <= acc;
            ovf <= (ovf && !ov_clr) || (op_valid && alu_o.flags_upd && alu_o.ovf);
        end
    end

    // R10: an idle cycle holds the accumulator and its buffer
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc) && $stable(accb) && $stable(carry)));

    // R8: overflow flag stays set without a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ov_clr) |=> ovf);

    // R8: a clear with no arithmetic leaves the flag low
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_clr && !(op_valid && alu_o.flags_upd)) |=> !ovf);

    // R9: saturating overflow lands on an extreme
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ovm && alu_o.flags_upd && alu_o.ovf) |=>
        (acc == SAT_POS || acc == SAT_NEG));

    // R5: a full-width shift leaves the low half of a loaded value empty
    a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_LOAD && int'(shift_cnt) >= MAXSH) |=>
        (acc[DW-1:0] == '0));
endmodule

// File: tb/mac_datapath_test.sv
`timescale 1ns/1ps
module mac_datapath_test;
    import mac_dp_pkg::*;

    localparam real HALF = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [15:0] operand = 16'd0;
    logic [4:0]  shift_cnt = 5'd0;
    logic [1:0]  pscale_mode = 2'd0;
    logic        sxm = 1'b0, ovm = 1'b0, ov_clr = 1'b0;
    logic [31:0] acc, accb, preg;
    logic        carry, ovf;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_acc = '0, m_accb = '0, m_preg = '0;
    logic [15:0] m_treg = '0;
    logic        m_c = 1'b0, m_ov = 1'b0;
    string       cur_tag = "R1";

    always #(HALF) clk = ~clk;

    mac_datapath uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .operand(operand), .shift_cnt(shift_cnt), .pscale_mode(pscale_mode),
        .sxm(sxm), .ovm(ovm), .ov_clr(ov_clr),
        .acc(acc), .accb(accb), .preg(preg), .carry(carry), .ovf(ovf)
    );

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("acc",   acc,   m_acc);
        chk("accb",  accb,  m_accb);
        chk("preg",  preg,  m_preg);
        chk("carry", {31'd0, carry}, {31'd0, m_c});
        chk("ovf",   {31'd0, ovf},   {31'd0, m_ov});
    endtask

    // reference model: next state from the requirements
    task automatic model(bit v, op_e op, logic [15:0] opnd, int sh, int pm,
                         bit sx, bit om, bit clr);
        longint x, p, sa, sb, ss, ua, ub;
        logic [31:0] so, ps, b;
        bit sxe, is_add, is_sub;
        int cin, shc;
        logic [31:0] n_acc = m_acc, n_accb = m_accb, n_preg = m_preg;
        logic [15:0] n_treg = m_treg;
        logic n_c = m_c;
        logic n_ov = m_ov & ~clr;

        sxe = sx && !(op inside {OP_ADDC, OP_ADDU, OP_SUBB, OP_SUBU});
        x   = sxe ? longint'($signed(opnd)) : longint'(opnd);
        shc = (sh > 16) ? 16 : sh;
        x   = x << shc;
        so  = x[31:0];
        p   = longint'($signed(m_preg));
        case (pm)
            0: p = p;
            1: p = p << 1;
            2: p = p << 4;
            default: p = p >>> 6;
        endcase
        ps = p[31:0];

        is_add = op inside {OP_ADD, OP_ADDU, OP_ADDC, OP_ADDP};
        is_sub = op inside {OP_SUB, OP_SUBU, OP_SUBB, OP_SUBP};
        if (v) begin
            if (op == OP_LOAD)  n_acc  = so;
            if (op == OP_LOADP) n_acc  = ps;
            if (op == OP_LDT)   n_treg = opnd;
            if (op == OP_MPY) begin
                x = longint'($signed(m_treg)) * longint'($signed(opnd));
                n_preg = x[31:0];
            end
            if (op == OP_SAVEB) n_accb = m_acc;
            if (is_add || is_sub) begin
                b  = (op == OP_ADDP || op == OP_SUBP) ? ps : so;
                sa = longint'($signed(m_acc));
                sb = longint'($signed(b));
                ua = longint'(m_acc);
                ub = longint'(b);
                if (is_add) begin
                    cin = (op == OP_ADDC) ? int'(m_c) : 0;
                    ss  = sa + sb + cin;
                    n_c = (ua + ub + cin) >= 64'h1_0000_0000;
                end else begin
                    cin = (op == OP_SUBB) ? int'(m_c) : 1;
                    ss  = sa - sb - (1 - cin);
                    n_c = ua >= (ub + (1 - cin));
                end
                if (ss > 64'sd2147483647 || ss < -64'sd2147483648) begin
                    n_ov = 1'b1;
                    if (om) n_acc = (ss > 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
                    else    n_acc = ss[31:0];
                end else begin
                    n_acc = ss[31:0];
                end
            end
        end
        m_acc = n_acc; m_accb = n_accb; m_preg = n_preg; m_treg = n_treg;
        m_c = n_c; m_ov = n_ov;
    endtask

    task automatic step(string tag, bit v, op_e op, logic [15:0] opnd,
                        int sh = 0, int pm = 0, bit sx = 0, bit om = 0, bit clr = 0);
        @(negedge clk);
        compare_all();
        cur_tag     = tag;
        op_valid    = v;
        op_sel      = op;
        operand     = opnd;
        shift_cnt   = 5'(sh);
        pscale_mode = 2'(pm);
        sxm         = sx;
        ovm         = om;
        ov_clr      = clr;
        model(v, op, opnd, sh, pm, sx, om, clr);
    endtask

    initial begin
        #(HALF * 2 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state compared at the first step
        step("R1", 0, OP_NOP, 16'h0);

        // R2: multiplicand load and signed multiply
        step("R2", 1, OP_LDT, 16'hFFF0);
        step("R2", 1, OP_MPY, 16'h0003);
        step("R2", 1, OP_LDT, 16'h8000);
        step("R2", 1, OP_MPY, 16'h8000);

        // R3: scaler modes 00, 01, 10
        step("R2", 1, OP_LDT, 16'h1234);
        step("R2", 1, OP_MPY, 16'hF00F);
        step("R3", 1, OP_LOADP, 16'h0, 0, 0);
        step("R3", 1, OP_LOADP, 16'h0, 0, 1);
        step("R3", 1, OP_LOADP, 16'h0, 0, 2);
        step("R3", 1, OP_ADDP,  16'h0, 0, 1);
        step("R3", 1, OP_SUBP,  16'h0, 0, 2);

        // R4: arithmetic right shift ignores sxm
        step("R4", 1, OP_LDT, 16'hFFFF);
        step("R4", 1, OP_MPY, 16'h0040);
        step("R4", 1, OP_LOADP, 16'h0, 0, 3, 0);
        step("R4", 1, OP_LDT, 16'h7FFF);
        step("R4", 1, OP_MPY, 16'h7FFF);
        step("R4", 1, OP_LOADP, 16'h0, 0, 3, 1);
        step("R4", 1, OP_LDT, 16'h8001);
        step("R4", 1, OP_MPY, 16'h7FFF);
        step("R4", 1, OP_LOADP, 16'h0, 0, 3, 0);

        // R5: input shifter, including counts beyond 16
        step("R5", 1, OP_LOAD, 16'h8001, 0);
        step("R5", 1, OP_LOAD, 16'h8001, 7);
        step("R5", 1, OP_LOAD, 16'h8001, 16, 0, 1);
        step("R5", 1, OP_LOAD, 16'hC3A5, 20);
        step("R5", 1, OP_LOAD, 16'hC3A5, 31, 0, 1);

        // R6: sign extension on and off, bypassed by the unsigned variants
        step("R6", 1, OP_LOAD, 16'h8000, 4, 0, 1);
        step("R6", 1, OP_LOAD, 16'h8000, 4, 0, 0);
        step("R6", 1, OP_ADDU, 16'hFFFF, 0, 0, 1);
        step("R6", 1, OP_SUBU, 16'hFFFF, 8, 0, 1);
        step("R6", 1, OP_ADD,  16'hFFFF, 0, 0, 1);
        step("R6", 1, OP_SUB,  16'h8000, 2, 0, 1);

        // R7: carry out, borrow, carry in
        step("R7", 1, OP_LOAD, 16'hFFFF, 16, 0, 1);
        step("R7", 1, OP_ADDU, 16'hFFFF, 0);
        step("R7", 1, OP_ADDU, 16'h0001, 0);
        step("R7", 1, OP_ADDC, 16'h0000, 0);
        step("R7", 1, OP_LDT,  16'h0005);
        step("R7", 1, OP_SUB,  16'h0002, 0);
        step("R7", 1, OP_SUBB, 16'h0000, 0);
        step("R7", 1, OP_SUBB, 16'h0000, 0);
        step("R7", 1, OP_LOAD, 16'h0000, 0);

        // R8: sticky overflow, clear, overflow and clear together
        step("R8", 1, OP_LOAD, 16'h7FFF, 16, 0, 1);
        step("R8", 1, OP_ADD,  16'h7FFF, 16, 0, 1, 0);
        step("R8", 1, OP_LOAD, 16'h0001, 0);
        step("R8", 0, OP_NOP,  16'h0);
        step("R8", 1, OP_LOAD, 16'h7FFF, 16, 0, 1, 0, 1);
        step("R8", 1, OP_ADD,  16'h7FFF, 16, 0, 1, 0, 1);
        step("R8", 0, OP_NOP,  16'h0, 0, 0, 0, 0, 1);
        step("R8", 0, OP_NOP,  16'h0);

        // R9: saturation both ways
        step("R9", 1, OP_LOAD, 16'h7FFF, 16, 0, 1);
        step("R9", 1, OP_ADD,  16'h7FFF, 16, 0, 1, 1);
        step("R9", 1, OP_LOAD, 16'h8000, 16, 0, 1, 0, 1);
        step("R9", 1, OP_SUB,  16'h7FFF, 16, 0, 1, 1);
        step("R9", 1, OP_SUB,  16'h0001, 0, 0, 1, 1);

        // R10: buffer copy, idle and NOP hold
        step("R10", 1, OP_LOAD,  16'h5A5A, 3);
        step("R10", 1, OP_SAVEB, 16'h0);
        step("R10", 0, OP_ADD,   16'h1111, 4);
        step("R10", 0, OP_MPY,   16'h2222);
        step("R10", 1, OP_NOP,   16'h3333);
        step("R10", 1, OP_LOAD,  16'h0F0F, 0);
        step("R10", 1, OP_SAVEB, 16'h0);

        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            op_e r_op;
            r_op = op_e'($urandom_range(0, 13));
            step("random", ($urandom_range(0, 7) != 0), r_op, 16'($urandom),
                 $urandom_range(0, 31), $urandom_range(0, 3),
                 1'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0));
        end

        step("final", 0, OP_NOP, 16'h0);
        @(negedge clk);
        compare_all();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule